// File: doc/BRIEF.md
# I2C Target with High-Speed Mode Entry

This block is the serial front end of an I2C target. It oversamples SCL and SDA on a fast system clock and cleans both lines with a glitch filter. From the filtered lines it recovers start, repeated start and stop conditions. It shifts bytes in and out and pulls SDA low through an open-drain enable whenever it acknowledges a byte or sends a zero. Behind the front end sits a small register file. A controller writes one register with the sequence: target address with the write bit, register pointer, data byte. To read, the controller writes the pointer, issues a repeated start with the read bit and clocks one byte back.

The block also follows the bus speed. When the first byte after a start is the high-speed controller code, the target does not acknowledge that byte. It sets a mode flag, which cuts the glitch filter from four samples to one so that faster transfers can pass. The flag survives any number of repeated starts and is cleared only by a stop.

Top module: `i2c_hs_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal TGT_ADDR (default 7'h42), and then acknowledges the pointer byte and the data byte that follow. It leaves SDA released for any other address. Bit 0 of the address byte is the direction: 0 means write, 1 means read.
- R2: A write of the form address+W, pointer, data stores the data byte in the register selected by the pointer.
- R3: After the pointer is written, a repeated start with address+R returns the selected register, most significant bit first. The target changes SDA only while SCL is low.
- R4: A pointer at or above NUM_REGS (default 4) reads back 0x00, and a write to such a pointer changes no register.
- R5: When a byte of the form 00001xxx is the first byte after a start and the mode flag is clear, the target leaves SDA released during its acknowledge clock.
- R6: After that byte, the output hs_mode reads 1.
- R7: hs_mode stays 1 across repeated starts and through the transfers that follow them.
- R8: A stop condition clears hs_mode. Reset also leaves hs_mode at 0 and SDA released.
- R9: The 00001xxx pattern is ordinary data anywhere else. As a data byte it is stored normally. As the first byte after a repeated start while hs_mode is 1, it is treated as a non-matching address and is not acknowledged.
- R10: While hs_mode is 0, a line pulse shorter than FILT_SLOW (default 4) system clocks is ignored. While hs_mode is 1, a pulse of two clocks is already seen, so a short SDA rise while SCL is high counts as a stop.
- R11: A start condition in the middle of a byte abandons the partial byte. A complete transfer that follows is handled normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| hs_mode | output | 1 | 1 while the bus is in high-speed mode |

## Verification
The bench sends the high-speed code and expects no acknowledge. A target that acknowledged it would corrupt a bus with several targets. It then runs a write and a read, each behind its own repeated start, and requires hs_mode to stay set until the stop. A design that cleared the flag on any start would fail there, and so would one that never cleared it. The code pattern is also sent as stored data and as a later address, which catches a matcher that looks at every byte. An unmapped pointer must read back 0x00 rather than an aliased register. The same two-clock SDA pulse is injected in both speed modes: it must be filtered in standard mode and must count as a stop in high-speed mode, which exposes a filter whose depth does not follow the mode. An abandoned half byte checks that a start resets the bit count.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_REG, PH_WDATA, PH_RDATA, PH_SKIP
  } phase_t;

  function automatic logic is_hs_code(input logic [7:0] b);
    return b[7:3] == 5'b00001;
  endfunction

  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] tgt);
    return b[7:1] == tgt;
  endfunction
endpackage

// File: rtl/i2c_hs_glitch.sv
module i2c_hs_glitch #(
  parameter int SLOW = 4,
  parameter int FAST = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(SLOW + 1);
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = fast ? CW'(FAST - 1) : CW'(SLOW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      cnt  <= '0;
      filt <= 1'b1;
    end else begin
      sync <= {sync[0], raw};
      if (sync[1] == filt) cnt <= '0;
      else if (cnt >= lim) begin
        filt <= sync[1];
        cnt  <= '0;
      end else cnt <= cnt + 1'b1;
    end
  end

  // Filtered level only moves toward the synchronized input (R10)
  assert_filter_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> ($past(sync[1]) == filt));
endmodule

// File: rtl/i2c_hs_cond.sv
module i2c_hs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start_evt = scl && scl_q && sda_q && !sda;
  assign stop_evt  = scl && scl_q && !sda_q && sda;
  assign scl_rise  = scl && !scl_q;
  assign scl_fall  = !scl && scl_q;
endmodule

// File: rtl/i2c_hs_regs.sv
module i2c_hs_regs #(
  parameter int NUM_REGS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] ptr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] NREG = 8'(NUM_REGS);
  logic [7:0] mem [NUM_REGS];
  logic       mapped;

  assign mapped = ptr < NREG;
  assign rdata  = mapped ? mem[ptr[IW-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= 8'h00;
    end else if (we && mapped) begin
      mem[ptr[IW-1:0]] <= wdata;
    end
  end
endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target #(
  parameter logic [6:0] TGT_ADDR  = 7'h42,
  parameter int         NUM_REGS  = 4,
  parameter int         FILT_SLOW = 4,
  parameter int         FILT_FAST = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull,
  output logic hs_mode
);
  import i2c_hs_pkg::*;

  logic [1:0] raw, filt;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_hs_glitch #(.SLOW(FILT_SLOW), .FAST(FILT_FAST)) u_glitch (
      .clk(clk), .rst_n(rst_n), .fast(hs_mode), .raw(raw[g]), .filt(filt[g]));
  end

  logic start_evt, stop_evt, scl_rise, scl_fall;
  i2c_hs_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl(filt[0]), .sda(filt[1]),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  phase_t     phase, nxt_q, nxt_c;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, tx, ptr, rdata;
  logic       ack_slot, hs_chk, give_ack;
  logic       byte_done, hs_code_evt, wr_en;

  assign byte_done   = scl_fall && !ack_slot && bit_cnt == 4'd8 && phase != PH_IDLE;
  assign hs_code_evt = byte_done && phase == PH_ADDR && hs_chk && is_hs_code(shreg);
  assign wr_en       = byte_done && phase == PH_WDATA;

  always_comb begin
    give_ack = 1'b0;
    nxt_c    = PH_SKIP;
    case (phase)
      PH_ADDR: if (!hs_code_evt && addr_hit(shreg, TGT_ADDR)) begin
        give_ack = 1'b1;
        nxt_c    = shreg[0] ? PH_RDATA : PH_REG;
      end
      PH_REG:   begin give_ack = 1'b1; nxt_c = PH_WDATA; end
      PH_WDATA: give_ack = 1'b1;
      default:  ;
    endcase
  end

  i2c_hs_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .ptr(ptr), .wdata(shreg), .rdata(rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      nxt_q    <= PH_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx       <= '0;
      ptr      <= '0;
      ack_slot <= 1'b0;
      hs_chk   <= 1'b0;
      hs_mode  <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_evt) begin
      phase    <= PH_IDLE;
      hs_mode  <= 1'b0;
      bit_cnt  <= '0;
      ack_slot <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_evt) begin
      phase    <= PH_ADDR;
      hs_chk   <= !hs_mode;
      bit_cnt  <= '0;
      ack_slot <= 1'b0;
      sda_pull <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise && !ack_slot) begin
        shreg   <= {shreg[6:0], filt[1]};
        bit_cnt <= bit_cnt + 4'd1;
      end
      if (byte_done) begin
        ack_slot <= 1'b1;
        hs_chk   <= 1'b0;
        sda_pull <= give_ack;
        nxt_q    <= nxt_c;
        if (hs_code_evt) hs_mode <= 1'b1;
        if (phase == PH_REG) ptr <= shreg;
      end else if (scl_fall && ack_slot) begin
        ack_slot <= 1'b0;
        bit_cnt  <= '0;
        phase    <= nxt_q;
        if (nxt_q == PH_RDATA) begin
          tx       <= rdata;
          sda_pull <= !rdata[7];
        end else sda_pull <= 1'b0;
      end else if (scl_fall && phase == PH_RDATA && bit_cnt != 4'd0) begin
        sda_pull <= !tx[3'd7 - bit_cnt[2:0]];
      end
    end
  end

  // The high-speed code is never acknowledged (R5)
  assert_hs_no_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_code_evt |=> !sda_pull);
  // Recognizing the code raises the mode flag (R6)
  assert_hs_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_code_evt |=> hs_mode);
  // A repeated start keeps high-speed mode (R7)
  assert_hs_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && hs_mode) |=> hs_mode);
  // A stop always leaves high-speed mode (R8)
  assert_stop_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !hs_mode);
  // SDA is released while no transfer is in progress (R1)
  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_pull);
  // Read data moves only on a falling SCL edge or at a condition (R3)
  assert_read_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RDATA && !scl_fall && !start_evt && !stop_evt) |=> $stable(sda_pull));
endmodule

// File: tb/i2c_hs_target_bench.sv
module i2c_hs_target_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, hs_mode;
  wire  sda_bus = sda_m & ~sda_pull;
  int   checks = 0, fails = 0, q = 12;
  bit   done = 0;

  always #4 clk = ~clk;

  i2c_hs_target u_i2c_hs_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull(sda_pull), .hs_mode(hs_mode));

  localparam logic [7:0] AW = 8'h84, AR = 8'h85;

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic bus_start;
    sda_m = 1; w(q); scl_m = 1; w(q); sda_m = 0; w(q); scl_m = 0; w(q);
  endtask

  task automatic bus_stop;
    sda_m = 0; w(q); scl_m = 1; w(q); sda_m = 1; w(q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; w(q); scl_m = 1;
      if (glitch && i == 7) begin
        w(2); sda_m = ~b[i]; w(2); sda_m = b[i]; w(q - 4);
      end else w(q);
      scl_m = 0; w(q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    send_bits(b, 8, glitch);
    sda_m = 1; w(q); scl_m = 1; w(q / 2);
    ack = !sda_bus; w(q - q / 2); scl_m = 0; w(q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] d);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      w(q); scl_m = 1; w(q / 2); d[i] = sda_bus; w(q - q / 2); scl_m = 0;
    end
    w(q); sda_m = nack; w(q); scl_m = 1; w(q); scl_m = 0; w(q); sda_m = 1;
  endtask

  task automatic do_write(input logic [7:0] p, input logic [7:0] d);
    bit a;
    bus_start;
    send_byte(AW, 0, a); chk("R1 addr ack", a, 1);
    send_byte(p, 0, a);  chk("R1 ptr ack", a, 1);
    send_byte(d, 0, a);  chk("R1 data ack", a, 1);
  endtask

  task automatic do_read(input logic [7:0] p, output logic [7:0] d);
    bit a;
    bus_start;
    send_byte(AW, 0, a); chk("R1 addr ack", a, 1);
    send_byte(p, 0, a);  chk("R1 ptr ack", a, 1);
    bus_start;
    send_byte(AR, 0, a); chk("R1 read addr ack", a, 1);
    recv_byte(1, d);
  endtask

  task automatic enter_hs;
    bit a;
    bus_start;
    send_byte(8'h0D, 0, a);
    chk("R5 hs code not acked", a, 0);
    chk("R6 hs_mode set", hs_mode, 1);
    q = 6;
  endtask

  task automatic t_reset;
    chk("R8 reset hs_mode", hs_mode, 0);
    chk("R8 reset sda released", sda_pull, 0);
  endtask

  task automatic t_write_read;
    logic [7:0] d;
    do_write(8'h01, 8'hA5); bus_stop;
    do_read(8'h01, d); bus_stop;
    chk("R2 R3 readback reg1", d, 8'hA5);
    do_write(8'h02, 8'h5A); bus_stop;
    do_read(8'h02, d); bus_stop;
    chk("R3 readback reg2", d, 8'h5A);
  endtask

  task automatic t_wrong_addr;
    bit a;
    bus_start; send_byte(8'h86, 0, a); bus_stop;
    chk("R1 foreign address nacked", a, 0);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    do_write(8'h20, 8'h77); bus_stop;
    do_read(8'h20, d); bus_stop;
    chk("R4 unmapped reads zero", d, 8'h00);
    do_read(8'h00, d); bus_stop;
    chk("R4 unmapped write left reg0", d, 8'h00);
  endtask

  task automatic t_hs_session;
    logic [7:0] d;
    enter_hs;
    do_write(8'h02, 8'h3C);
    chk("R7 hs after first Sr", hs_mode, 1);
    do_read(8'h02, d);
    chk("R7 hs read data", d, 8'h3C);
    chk("R7 hs after second Sr", hs_mode, 1);
    bus_stop;
    chk("R8 stop clears hs", hs_mode, 0);
    q = 12;
  endtask

  task automatic t_pattern_as_data;
    logic [7:0] d;
    bit a;
    do_write(8'h00, 8'h0A); bus_stop;
    chk("R9 data byte no hs", hs_mode, 0);
    do_read(8'h00, d); bus_stop;
    chk("R9 pattern stored", d, 8'h0A);
    enter_hs;
    bus_start; send_byte(8'h09, 0, a);
    chk("R9 pattern as address nacked", a, 0);
    chk("R9 hs kept", hs_mode, 1);
    bus_stop; q = 12;
  endtask

  task automatic t_abort;
    logic [7:0] d;
    bus_start; send_bits(8'hFF, 4, 0); scl_m = 0;
    do_write(8'h03, 8'h5E); bus_stop;
    do_read(8'h03, d); bus_stop;
    chk("R11 write after aborted byte", d, 8'h5E);
  endtask

  task automatic t_filter;
    logic [7:0] d;
    bit a;
    bus_start;
    send_byte(AW, 0, a); send_byte(8'h03, 0, a);
    send_byte(8'h11, 1, a);
    chk("R10 short pulse filtered, ack", a, 1);
    bus_stop;
    do_read(8'h03, d); bus_stop;
    chk("R10 slow filter kept write", d, 8'h11);
    enter_hs;
    bus_start;
    send_byte(AW, 0, a); send_byte(8'h03, 0, a);
    send_byte(8'h22, 1, a);
    chk("R10 fast filter sees stop", hs_mode, 0);
    bus_stop; q = 12;
    do_read(8'h03, d); bus_stop;
    chk("R10 aborted write left reg3", d, 8'h11);
  endtask

  initial begin
    w(5); rst_n = 1; w(5);
    t_reset;
    t_write_read;
    t_wrong_addr;
    t_unmapped;
    t_hs_session;
    t_pattern_as_data;
    t_abort;
    t_filter;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule